// File: doc/BRIEF.md
# Oversampled Serial Receiver with Selectable Parity and Stop Length

This block takes one asynchronous serial line and turns each incoming character into a parallel word. A reload counter, loaded from a 16-bit divider input, produces a sampling enable; sixteen of these enables make one bit time. After a falling edge on the synchronised line, the receiver checks that the line is still low halfway through the start bit. It then takes every later bit at its centre, least significant data bit first.

A 2-bit mode selects how the parity slot is treated. The slot can be absent, checked for even parity, checked for odd parity, or simply captured and reported without any check. A 2-bit select sets the stop period to one, one and a half or two bit times. When the programmed stop period has elapsed, the word, the received parity bit, a parity error flag and a framing error flag are presented together with a one-clock valid pulse. The four outputs then hold their values until the next character completes.

Top module: `serial_rx_os16`

## Requirements
- R1: The sampling enable comes from a down-counter that reloads from `div_i` and fires for one clock each time it reaches zero, so one enable occurs every `div_i`+1 clocks and one bit lasts 16 enables.
- R2: The line passes through a two-stage synchroniser. A character begins at a high-to-low transition of the synchronised line. If the line is high again at the 8th enable after that transition, the start is dropped and no valid pulse follows.
- R3: Data bits (8 by default) are sampled 16 enables apart, starting 16 enables after the start confirmation, and are assembled least significant bit first on `data_o`.
- R4: With `par_mode_i` = 00 the frame has no parity slot, and `par_bit_o` and `par_err_o` are 0.
- R5: With `par_mode_i` = 01 a parity slot follows the data, and `par_err_o` is 1 exactly when the count of ones over data and parity bit is odd.
- R6: With `par_mode_i` = 10 a parity slot follows the data, and `par_err_o` is 1 exactly when that count is even.
- R7: With `par_mode_i` = 11 the parity slot is captured on `par_bit_o` and never flagged, so `par_err_o` is 0.
- R8: `stop_sel_i` = 00, 01 and 10 or 11 select stop periods of 16, 24 and 32 enables. The valid pulse is raised on the enable that ends the stop period, counted from the centre of the last data or parity bit.
- R9: `frame_err_o` is 1 when the line is low 16 enables after the centre of the last data or parity bit. The word is still delivered.
- R10: `valid_o` is a single-clock pulse, one per accepted character. `data_o`, `par_bit_o`, `par_err_o` and `frame_err_o` change only together with it.
- R11: After reset all outputs are 0 and stay 0 while the line idles high.
- R12: Characters sent back to back, with the next start bit directly after the nominal stop period, are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | 16 | Reload value; enable period is div_i+1 clocks |
| par_mode_i | input | 2 | 00 none, 01 even, 10 odd, 11 capture only |
| stop_sel_i | input | 2 | 00 one, 01 one and a half, 10/11 two stop bits |
| rxd_i | input | 1 | Serial line, idle high |
| data_o | output | 8 | Received word |
| valid_o | output | 1 | One-clock pulse when a character completes |
| par_bit_o | output | 1 | Received parity bit (0 when no parity slot) |
| par_err_o | output | 1 | Parity mismatch in even or odd mode |
| frame_err_o | output | 1 | Line low at the stop sample |

## Verification
The hardest case to reach from the ports is the interaction between the end of one character and the start of the next. The receiver has to return to idle before the following falling edge arrives, and it has to stay idle when a framing error leaves the line low. The stimulus sends runs of characters with no idle gap for each stop length, sends frames whose stop bit is held low and follows them with clean frames, and pulses the line low for a few enables to exercise a rejected start. Every byte value is swept at the fastest divider, and the valid pulse is checked against a timing window computed from the divider and frame shape.

// File: rtl/uart_os_pkg.sv
package uart_os_pkg;

    localparam int OS_RATE    = 16;
    localparam int CONFIRM_AT = OS_RATE / 2 - 1;
    localparam int TCNT_W     = 6;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_USER = 2'b11
    } par_mode_e;

    typedef enum logic [1:0] {
        STOP_ONE      = 2'b00,
        STOP_ONE_HALF = 2'b01,
        STOP_TWO      = 2'b10,
        STOP_TWO_ALT  = 2'b11
    } stop_sel_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } rx_state_e;

    typedef struct packed {
        par_mode_e par;
        stop_sel_e stop;
    } rx_cfg_t;

    function automatic logic [TCNT_W-1:0] stop_len(input stop_sel_e s);
        case (s)
            STOP_ONE:      return TCNT_W'(OS_RATE);
            STOP_ONE_HALF: return TCNT_W'(OS_RATE + OS_RATE / 2);
            default:       return TCNT_W'(2 * OS_RATE);
        endcase
    endfunction

    function automatic logic par_check(input par_mode_e m, input logic dpar, input logic p);
        case (m)
            PAR_EVEN: return dpar ^ p;
            PAR_ODD:  return ~(dpar ^ p);
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic par_report(input par_mode_e m, input logic p);
        return (m == PAR_NONE) ? 1'b0 : p;
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b1;
        else     chain_q[0] <= d_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[g] <= 1'b1;
            else     chain_q[g] <= chain_q[g-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] div_i,
    output logic             tick_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q  <= div_i;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q - 1'b1;
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

    a_r1_reload: assert property (@(posedge clk) disable iff (rst)
        tick_q |-> cnt_q == $past(div_i));

    a_r1_gap: assert property (@(posedge clk) disable iff (rst)
        (tick_q && cnt_q != '0) |=> !tick_q);
endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
    import uart_os_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          line_i,
    input  logic [1:0]    par_mode_i,
    input  logic [1:0]    stop_sel_i,
    output logic [DW-1:0] data_o,
    output logic          valid_o,
    output logic          par_bit_o,
    output logic          par_err_o,
    output logic          frame_err_o
);
    localparam int IDX_W = (DW > 1) ? $clog2(DW) : 1;

    rx_state_e         state_q;
    rx_cfg_t           cfg_q;
    logic [TCNT_W-1:0] tcnt_q;
    logic [IDX_W-1:0]  bidx_q;
    logic [DW-1:0]     shreg_q;
    logic              pbit_q;
    logic              fe_q;
    logic              prev_q;

    logic              fall;
    logic              bit_end;
    logic              stop_mid;
    logic              fe_now;
    logic [TCNT_W-1:0] stop_last;

    always_comb begin
        fall      = prev_q & ~line_i;
        bit_end   = tick_i && (tcnt_q == TCNT_W'(OS_RATE - 1));
        stop_mid  = tcnt_q == TCNT_W'(OS_RATE - 1);
        fe_now    = stop_mid ? ~line_i : fe_q;
        stop_last = stop_len(cfg_q.stop) - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_IDLE;
            cfg_q       <= '{par: PAR_NONE, stop: STOP_ONE};
            tcnt_q      <= '0;
            bidx_q      <= '0;
            shreg_q     <= '0;
            pbit_q      <= 1'b0;
            fe_q        <= 1'b0;
            prev_q      <= 1'b1;
            data_o      <= '0;
            valid_o     <= 1'b0;
            par_bit_o   <= 1'b0;
            par_err_o   <= 1'b0;
            frame_err_o <= 1'b0;
        end else begin
            prev_q  <= line_i;
            valid_o <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (fall) begin
                        state_q <= S_START;
                        tcnt_q  <= '0;
                        cfg_q   <= '{par: par_mode_e'(par_mode_i), stop: stop_sel_e'(stop_sel_i)};
                    end
                end
                S_START: begin
                    if (tick_i) begin
                        if (tcnt_q == TCNT_W'(CONFIRM_AT)) begin
                            tcnt_q <= '0;
                            bidx_q <= '0;
                            state_q <= line_i ? S_IDLE : S_DATA;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                end
                S_DATA: begin
                    if (bit_end) begin
                        tcnt_q  <= '0;
                        shreg_q <= {line_i, shreg_q[DW-1:1]};
                        if (bidx_q == IDX_W'(DW - 1)) begin
                            fe_q    <= 1'b0;
                            pbit_q  <= 1'b0;
                            state_q <= (cfg_q.par == PAR_NONE) ? S_STOP : S_PAR;
                        end else begin
                            bidx_q <= bidx_q + 1'b1;
                        end
                    end else if (tick_i) begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                S_PAR: begin
                    if (bit_end) begin
                        tcnt_q  <= '0;
                        pbit_q  <= line_i;
                        state_q <= S_STOP;
                    end else if (tick_i) begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                S_STOP: begin
                    if (tick_i) begin
                        fe_q <= fe_now;
                        if (tcnt_q == stop_last) begin
                            state_q     <= S_IDLE;
                            tcnt_q      <= '0;
                            valid_o     <= 1'b1;
                            data_o      <= shreg_q;
                            par_bit_o   <= par_report(cfg_q.par, pbit_q);
                            par_err_o   <= par_check(cfg_q.par, ^shreg_q, pbit_q);
                            frame_err_o <= fe_now;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    a_r10_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(data_o) && $stable(par_err_o) && $stable(frame_err_o)));

    a_r7_no_flag: assert property (@(posedge clk) disable iff (rst)
        (valid_o && (cfg_q.par == PAR_NONE || cfg_q.par == PAR_USER)) |-> !par_err_o);

    a_r9_flag_with_valid: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_err_o) |-> valid_o);

    a_r8_on_tick: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(tick_i));
endmodule

// File: rtl/serial_rx_os16.sv
module serial_rx_os16 #(
    parameter int DW    = 8,
    parameter int DIV_W = 16,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    input  logic [1:0]       par_mode_i,
    input  logic [1:0]       stop_sel_i,
    input  logic             rxd_i,
    output logic [DW-1:0]    data_o,
    output logic             valid_o,
    output logic             par_bit_o,
    output logic             par_err_o,
    output logic             frame_err_o
);
    logic line_s;
    logic tick;

    rx_line_sync #(.STAGES(SYNC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (rxd_i),
        .q_o (line_s)
    );

    rx_tick_gen #(.CNT_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .div_i  (div_i),
        .tick_o (tick)
    );

    rx_frame_engine #(.DW(DW)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick),
        .line_i      (line_s),
        .par_mode_i  (par_mode_i),
        .stop_sel_i  (stop_sel_i),
        .data_o      (data_o),
        .valid_o     (valid_o),
        .par_bit_o   (par_bit_o),
        .par_err_o   (par_err_o),
        .frame_err_o (frame_err_o)
    );
endmodule

// File: tb/serial_rx_os16_test.sv
module serial_rx_os16_test;
    localparam int LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] div = 16'd1;
    logic [1:0]  par_mode = 2'b00;
    logic [1:0]  stop_sel = 2'b00;
    logic        rxd = 1'b1;
    logic [7:0]  data_o;
    logic        valid_o, par_bit_o, par_err_o, frame_err_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int vcount = 0;
    int vcyc   = 0;
    int dv     = 1;
    bit done   = 1'b0;

    serial_rx_os16 uut (
        .clk(clk), .rst(rst), .div_i(div), .par_mode_i(par_mode),
        .stop_sel_i(stop_sel), .rxd_i(rxd), .data_o(data_o), .valid_o(valid_o),
        .par_bit_o(par_bit_o), .par_err_o(par_err_o), .frame_err_o(frame_err_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (valid_o) begin
            vcount = vcount + 1;
            vcyc   = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (cyc > LIMIT && !done) begin
            done = 1'b1;
            chk(1'b0, "R10 watchdog", cyc, LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic drive(input logic b, input int nticks);
        rxd = b;
        repeat (nticks * (dv + 1)) @(negedge clk);
    endtask

    task automatic set_div(input int d);
        dv  = d;
        div = 16'(d);
        drive(1'b1, 4);
    endtask

    task automatic send_frame(input logic [7:0] d, input int pm, input int ss,
                              input bit flip, input bit ubit, input bit stop_low, input int gap);
        int st, c0, t0, tt, lo, hi, dt;
        logic p;
        logic exp_pb, exp_pe;
        string ptag;
        par_mode = pm[1:0];
        stop_sel = ss[1:0];
        st = (ss == 0) ? 16 : (ss == 1) ? 24 : 32;
        p  = (pm == 1) ? ^d : (pm == 2) ? ~(^d) : ubit;
        if (flip && (pm == 1 || pm == 2)) p = ~p;
        c0 = vcount;
        t0 = cyc;
        drive(1'b0, 16);
        for (int i = 0; i < 8; i++) drive(d[i], 16);
        if (pm != 0) drive(p, 16);
        drive(stop_low ? 1'b0 : 1'b1, st);
        if (gap > 0) drive(1'b1, gap);
        tt = (9 + ((pm != 0) ? 1 : 0)) * 16 - 8 + st;
        lo = tt * (dv + 1) - (dv + 1);
        hi = tt * (dv + 1) + (dv + 1) + 6;
        dt = vcyc - t0;
        case (pm)
            0: ptag = "R4";
            1: ptag = "R5";
            2: ptag = "R6";
            default: ptag = "R7";
        endcase
        exp_pb = (pm == 0) ? 1'b0 : p;
        exp_pe = (pm == 1 || pm == 2) ? flip : 1'b0;
        chk(vcount == c0 + 1, "R10 one valid per frame", vcount - c0, 1);
        chk(data_o == d, "R3 data lsb first", data_o, d);
        chk(dt >= lo && dt <= hi, "R8 valid timing", dt, tt * (dv + 1));
        chk(frame_err_o == stop_low, "R9 framing flag", frame_err_o, stop_low);
        chk(par_bit_o == exp_pb, {ptag, " parity bit"}, par_bit_o, exp_pb);
        chk(par_err_o == exp_pe, {ptag, " parity error"}, par_err_o, exp_pe);
    endtask

    initial begin
        logic [7:0] pats [6];
        int c0;
        logic [7:0] last;
        pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk(valid_o == 1'b0 && data_o == 8'h00, "R11 reset outputs", {valid_o, data_o}, 0);
        chk(par_bit_o == 1'b0 && par_err_o == 1'b0 && frame_err_o == 1'b0,
            "R11 reset flags", {par_bit_o, par_err_o, frame_err_o}, 0);
        drive(1'b1, 40);
        chk(vcount == 0, "R11 idle line no valid", vcount, 0);

        // sweep of parity modes and stop lengths (R4..R8)
        set_div(1);
        for (int pm = 0; pm < 4; pm++)
            for (int ss = 0; ss < 4; ss++)
                for (int k = 0; k < 6; k++)
                    send_frame(pats[k], pm, ss, k[0], k[1], 1'b0, 16);

        // R1: other divider values
        set_div(4);
        send_frame(8'h3C, 1, 0, 1'b0, 1'b0, 1'b0, 8);
        send_frame(8'hC7, 2, 2, 1'b1, 1'b0, 1'b0, 8);
        set_div(2);
        send_frame(8'h96, 3, 1, 1'b0, 1'b1, 1'b0, 8);

        // R9: stop held low, then clean frames
        set_div(1);
        send_frame(8'h4E, 1, 0, 1'b0, 1'b0, 1'b1, 32);
        send_frame(8'hB1, 0, 2, 1'b0, 1'b0, 1'b1, 32);
        send_frame(8'h72, 2, 0, 1'b0, 1'b0, 1'b0, 16);

        // R2: short low pulse is dropped; R10: outputs hold
        last = data_o;
        c0 = vcount;
        drive(1'b0, 3);
        drive(1'b1, 48);
        chk(vcount == c0, "R2 false start ignored", vcount - c0, 0);
        chk(data_o == last, "R10 data held", data_o, last);
        send_frame(8'hE4, 1, 1, 1'b0, 1'b0, 1'b0, 16);

        // R12: back-to-back characters
        for (int k = 0; k < 5; k++)
            send_frame(8'(8'h11 * (k + 1)), 1, 1, 1'b0, 1'b0, 1'b0, 0);
        drive(1'b1, 16);
        for (int k = 0; k < 4; k++)
            send_frame(8'(8'h0F << k), 0, 0, 1'b0, 1'b0, 1'b0, 0);
        drive(1'b1, 16);

        // R3: every byte value at the fastest divider
        set_div(0);
        for (int v = 0; v < 256; v++)
            send_frame(8'(v), 3, 1, 1'b0, v[3], 1'b0, 12);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule